// File: doc/BRIEF.md
# Two-Input Edge-Conditioned Output Controller

This block watches two level inputs, `in_a` and `in_b`, and drives one registered output, `z_out`. The output is set by a falling edge on `in_b` while `in_a` is high. It is cleared by a rising edge on `in_a` while `in_b` is high. Every other input change leaves it unchanged. The block is the clocked form of a fundamental-mode controller. Both inputs pass through a reset-cleared synchroniser. Each new synchronised pair is then compared with the pair held in the state register, and a single-input change is classified as a set, a clear or a hold.

The state register holds the last accepted input pair together with the output value. Each combination of pair and output is a named state. When both synchronised inputs differ from the stored pair in the same sample, the transition is unspecified. The block then raises `dual_flag` for one cycle, keeps `z_out` unchanged, and takes the new pair as the stored pair. The next change is judged against that pair.

Top module: `edge_gate_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `z_out` becomes 0, `dual_flag` becomes 0, and the stored pair becomes a=0, b=0.
- R2: When the stored pair is a=1,b=1 and the synchronised pair becomes a=1,b=0, `z_out` becomes 1. If `z_out` is already 1, it stays 1.
- R3: When the stored pair is a=0,b=1 and the synchronised pair becomes a=1,b=1, `z_out` becomes 0. If `z_out` is already 0, it stays 0.
- R4: Every other single-input change leaves `z_out` unchanged: a rising with b low, a falling, b rising, or b falling with a low.
- R5: When both synchronised inputs change in the same sample, `dual_flag` is 1 for exactly the one cycle in which the change is reported, and `z_out` keeps its value.
- R6: After a change of both inputs, the stored pair equals the new input pair. The next single-input change is classified against it.
- R7: With the default two synchroniser stages, an input change made just after rising edge P0 first appears on `z_out` and `dual_flag` after rising edge P3, and not after P2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_a | input | 1 | Level input a; its rising edge clears the output while b is high |
| in_b | input | 1 | Level input b; its falling edge sets the output while a is high |
| z_out | output | 1 | Registered output |
| dual_flag | output | 1 | One-cycle pulse when both inputs changed in one sample |

## Verification
The bench runs set and clear edges with the output already at the target value. A design that toggled instead of setting or clearing would then flip `z_out`. It runs all four neutral single changes, which catches a design that qualifies on the wrong input level or the wrong edge direction. It changes both inputs at once with `z_out` at 1 and at 0, then makes a single change from the new pair. A design that dropped the resynchronisation would misjudge that change, and one that acted on a double change would corrupt `z_out`. Every change is also sampled one cycle before its expected response and one cycle after it, so an off-by-one latency or a `dual_flag` longer than one cycle shows up.

// File: rtl/edgectl_pkg.sv
// Package: shared types of the edge-conditioned output controller.
// Assumes the input pair is packed as {a, b} and the state as {a, b, z}.
package edgectl_pkg;

    localparam int PAIR_W = 2;

    // One state for each stored input pair and output value; encoding {a, b, z}.
    typedef enum logic [2:0] {
        ST_00_LO = 3'b000,
        ST_00_HI = 3'b001,
        ST_01_LO = 3'b010,
        ST_01_HI = 3'b011,
        ST_10_LO = 3'b100,
        ST_10_HI = 3'b101,
        ST_11_LO = 3'b110,
        ST_11_HI = 3'b111
    } ctl_state_t;

    // Classification of one synchronised sample against the stored pair.
    typedef struct packed {
        logic set_z;
        logic clr_z;
        logic dual;
        logic moved;
    } edge_ev_t;

    // Builds the state that rests on the given pair with the given output.
    function automatic ctl_state_t mk_state(input logic [PAIR_W-1:0] pair,
                                            input logic z);
        return ctl_state_t'({pair, z});
    endfunction

endpackage

// File: rtl/edgectl_sync.sv
// Module: multi-stage synchroniser, one flip-flop chain per bit.
// Assumes STAGES >= 2 and that each input bit is an independent level.
module edgectl_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain [WIDTH];

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        // Shift the bit through its stage chain; a synchronous reset clears it.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[b] <= '0;
            else        chain[b] <= {chain[b][STAGES-2:0], d_async[b]};
        end
        assign q_sync[b] = chain[b][LAST];
    end

endmodule

// File: rtl/edgectl_detect.sv
// Module: compares the synchronised pair with the stored pair and classifies it.
// Assumes pair bit 1 is input a and bit 0 is input b. Purely combinational.
module edgectl_detect
    import edgectl_pkg::*;
(
    input  logic [PAIR_W-1:0] samp,
    input  logic [PAIR_W-1:0] pair,
    output edge_ev_t          ev
);

    logic [PAIR_W-1:0] diff;
    logic              single;

    // Find which inputs moved and classify a single move as set or clear.
    always_comb begin
        diff     = samp ^ pair;
        single   = ^diff;
        ev.moved = |diff;
        ev.dual  = &diff;
        ev.set_z = single && (pair == 2'b11) && (samp == 2'b10);
        ev.clr_z = single && (pair == 2'b01) && (samp == 2'b11);
    end

endmodule

// File: rtl/edgectl_fsm.sv
// Module: state register holding the stored pair and the output value.
// Assumes the events come from edgectl_detect for the same sample.
module edgectl_fsm
    import edgectl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAIR_W-1:0] samp,
    input  edge_ev_t          ev,
    output logic [PAIR_W-1:0] pair,
    output logic              z,
    output logic              dual_q
);

    ctl_state_t state_q;
    logic       z_next;

    // Work out the output value for the state that follows this sample.
    always_comb begin
        z_next = state_q[0];
        if (ev.set_z)      z_next = 1'b1;
        else if (ev.clr_z) z_next = 1'b0;
    end

    // Move to the new resting state and register the double-change pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_00_LO;
            dual_q  <= 1'b0;
        end else begin
            dual_q <= ev.dual;
            if (ev.moved) state_q <= mk_state(samp, z_next);
        end
    end

    assign pair = state_q[2:1];
    assign z    = state_q[0];

endmodule

// File: rtl/edge_gate_ctrl.sv
// Module: top of the two-input edge-conditioned output controller.
// Assumes in_a and in_b are asynchronous levels; z_out comes straight from a flop.
module edge_gate_ctrl
    import edgectl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_a,
    input  logic in_b,
    output logic z_out,
    output logic dual_flag
);

    logic [PAIR_W-1:0] samp_w;
    logic [PAIR_W-1:0] pair_w;
    edge_ev_t          ev_w;

    edgectl_sync #(.WIDTH(PAIR_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({in_a, in_b}),
        .q_sync  (samp_w)
    );

    edgectl_detect i_detect (
        .samp (samp_w),
        .pair (pair_w),
        .ev   (ev_w)
    );

    edgectl_fsm i_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .samp   (samp_w),
        .ev     (ev_w),
        .pair   (pair_w),
        .z      (z_out),
        .dual_q (dual_flag)
    );

endmodule

// File: rtl/edge_gate_ctrl_chk.sv
// Module: property checker for edge_gate_ctrl, bound to every instance.
// Assumes samp is the synchroniser output and pair is the stored pair.
module edge_gate_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] samp,
    input logic [1:0] pair,
    input logic       z,
    input logic       ill
);

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!z && !ill && pair == 2'b00));

    a_r2_set_on_b_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (pair == 2'b11 && samp == 2'b10) |=> z);

    a_r3_clear_on_a_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (pair == 2'b01 && samp == 2'b11) |=> !z);

    a_r4_neutral_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(pair ^ samp) == 1 &&
         !(pair == 2'b11 && samp == 2'b10) &&
         !(pair == 2'b01 && samp == 2'b11)) |=> $stable(z));

    a_r5_dual_keeps_z: assert property (@(posedge clk) disable iff (!rst_n)
        ill |-> $stable(z));

    a_r6_dual_resync: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(pair ^ samp) == 2) |=> (ill && pair == $past(samp)));

endmodule

bind edge_gate_ctrl edge_gate_ctrl_chk i_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .samp  (samp_w),
    .pair  (pair_w),
    .z     (z_out),
    .ill   (dual_flag)
);

// File: tb/test_edge_gate_ctrl.sv
`timescale 1ns/1ps
module test_edge_gate_ctrl;

    typedef struct {
        int         when;
        logic       z_exp;
        logic       d_exp;
        string      req;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_a = 1'b0;
    logic in_b = 1'b0;
    logic z_out;
    logic dual_flag;

    int    cyc = 0;
    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    item_t sb [$];

    logic [1:0] m_pair = 2'b00;
    logic       m_z = 1'b0;

    always #10 clk = ~clk;

    edge_gate_ctrl i_edge_gate_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_a      (in_a),
        .in_b      (in_b),
        .z_out     (z_out),
        .dual_flag (dual_flag)
    );

    // Monitor: count falling edges and compare the outputs with due items.
    always @(negedge clk) begin
        cyc++;
        while (sb.size() > 0 && sb[0].when <= cyc) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (it.when != cyc) begin
                failures++;
                $display("FAIL %s: item for cycle %0d missed at %0d", it.req, it.when, cyc);
            end else if (z_out !== it.z_exp || dual_flag !== it.d_exp) begin
                failures++;
                $display("FAIL %s: cycle %0d z=%b dual=%b expected z=%b dual=%b",
                         it.req, cyc, z_out, dual_flag, it.z_exp, it.d_exp);
            end
        end
    end

    task automatic push(input int when, input logic z, input logic d, input string req);
        item_t it;
        it.when = when; it.z_exp = z; it.d_exp = d; it.req = req;
        sb.push_back(it);
    endtask

    // Driver: reset the block; R1 expects z=0, dual=0 and stored pair 00.
    task automatic do_reset();
        @(posedge clk); #2;
        rst_n = 1'b0; in_a = 1'b0; in_b = 1'b0;
        push(cyc + 2, 1'b0, 1'b0, "R1");
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        m_pair = 2'b00; m_z = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    // Driver: apply a new pair, predict the response, and queue the three samples.
    task automatic step(input logic a, input logic b, input string req);
        logic [1:0] np;
        logic       old_z;
        logic       dual;
        int         n;
        @(posedge clk); #2;
        in_a = a; in_b = b;
        n = cyc;
        np = {a, b};
        old_z = m_z;
        dual = (np ^ m_pair) == 2'b11;
        if (!dual && m_pair == 2'b11 && np == 2'b10) m_z = 1'b1;
        if (!dual && m_pair == 2'b01 && np == 2'b11) m_z = 1'b0;
        m_pair = np;
        push(n + 3, old_z, 1'b0, "R7");
        push(n + 4, m_z, dual, req);
        push(n + 5, m_z, 1'b0, dual ? "R5" : req);
        repeat (4) @(posedge clk);
    endtask

    initial begin
        do_reset();                  // R1 at start-up
        step(1'b1, 1'b0, "R4");      // a rises, b low: hold 0
        step(1'b1, 1'b1, "R4");      // b rises: hold 0
        step(1'b1, 1'b0, "R2");      // b falls, a high: set
        step(1'b1, 1'b1, "R4");      // b rises: hold 1
        step(1'b1, 1'b0, "R2");      // set while already 1
        step(1'b0, 1'b0, "R4");      // a falls: hold 1
        step(1'b0, 1'b1, "R4");      // b rises with a low: hold 1
        step(1'b1, 1'b1, "R3");      // a rises, b high: clear
        step(1'b0, 1'b1, "R4");      // a falls: hold 0
        step(1'b1, 1'b1, "R3");      // clear while already 0
        step(1'b0, 1'b0, "R5");      // both change with z=0
        step(1'b0, 1'b1, "R4");      // b rises, a low: hold 0
        step(1'b0, 1'b0, "R4");      // b falls, a low: hold 0
        step(1'b1, 1'b1, "R5");      // both change
        step(1'b1, 1'b0, "R6");      // judged against 11: set
        step(1'b0, 1'b1, "R5");      // both change with z=1
        step(1'b1, 1'b1, "R6");      // judged against 01: clear
        step(1'b1, 1'b0, "R2");      // set again
        do_reset();                  // R1 with z at 1
        step(1'b0, 1'b1, "R4");      // after reset, from 00: hold 0
        while (sb.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish, pending=%0d expected 0", sb.size());
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule